// File: doc/BRIEF.md
# Status Register Write Protection Unit

This block keeps the status register of a serial nonvolatile memory and decides whether each write may go ahead. The register holds a busy flag, a write-enable latch, a two-bit region selector that marks part of the array as read-only, and an enable bit that arms the external write-protect pin. Command strobes come from an opcode decoder outside this block. The decoder also supplies the chip-select level, the active-low write-protect pin, the data byte for a status write and the target address for an array write.

For every request the block answers one cycle later with a single-cycle `grant` or `deny` pulse. A granted write starts a self-timed cycle: `busy` stays high for a fixed number of clock cycles, set by a parameter. When that cycle ends, the write-enable latch clears.

A status write is held pending until chip select is released. While it is pending, a low write-protect pin, when armed, can still abort it. Once the cycle has started, the pin no longer has any effect on it. The serial shifter, the opcode decoder and the storage array are outside this block.

Top module: `srwp_unit`

## Requirements
- R1: The status byte has busy at bit 0, the write-enable latch at bit 1, the region selector at bits 3:2, zeros at bits 6:4 and the pin-arm bit at bit 7. After reset the byte is 0x00 and `grant`, `deny` and `busy` are low.
- R2: When the block is idle, a `set_wel` strobe sets bit 1 and a `clr_wel` strobe clears it. The new value shows on the cycle after the strobe.
- R3: A status or array write request made while the latch is clear gets `deny` on the next cycle. It changes no state and does not start a cycle.
- R4: When bit 7 is 1 and `wp_n` is low, a status write request is denied and the latch is cleared. When bit 7 is 0, `wp_n` has no effect on status writes.
- R5: An accepted status write is held while `cs_n` is low and is committed in the cycle where `cs_n` is high. On commit, `grant` pulses, bits 3:2 and bit 7 take `sr_data[3:2]` and `sr_data[7]`, and the cycle starts. If `wp_n` is low with bit 7 set while the write is pending and `cs_n` is still low, the write is aborted: `deny` pulses, the latch clears and the status byte is unchanged. A commit in the same cycle takes precedence over the abort.
- R6: After a write cycle has started, changes on `wp_n` do not affect it, and the committed status bits stay in place.
- R7: `busy` is high for exactly `WRITE_CYCLES` cycles, starting in the cycle where `grant` is seen. The latch is clear once `busy` falls.
- R8: The region selector values are: 00 protects nothing; 01 protects the top quarter, where the two address MSBs are 11; 10 protects the top half, where the address MSB is 1; 11 protects the whole array. An array write to a protected address is denied, clears the latch and starts no cycle. Otherwise, with the latch set, it is granted.
- R9: Any request made while `busy` is high is denied and changes no state.
- R10: `grant` and `deny` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip-select level, low while a command is in progress |
| wp_n | input | 1 | Write-protect pin, active low |
| set_wel | input | 1 | Strobe: set the write-enable latch |
| clr_wel | input | 1 | Strobe: clear the write-enable latch |
| sr_req | input | 1 | Strobe: status write request |
| sr_data | input | 8 | Byte for a status write |
| arr_req | input | 1 | Strobe: array write request |
| arr_addr | input | ADDR_W | Target address of an array write |
| status | output | 8 | Status byte |
| grant | output | 1 | Pulse: the request was accepted and the write cycle starts |
| deny | output | 1 | Pulse: the request was refused |
| busy | output | 1 | The self-timed write cycle is in progress |

## Verification
The bench builds the block with `ADDR_W=6` and `WRITE_CYCLES=5`. With these values every boundary between protected regions falls on a small address (31/32 and 47/48), so all four selector values can be walked against edge addresses. The short busy window allows the cycle length to be counted exactly and `wp_n` to be toggled in the middle of a cycle. The sequences cover arming the pin with the pin already low, an abort while the write is pending, and a commit that lands in the same cycle as a falling pin.

// File: rtl/srwp_pkg.sv
package srwp_pkg;

    typedef enum logic [3:0] {
        EV_NONE,
        EV_SET_WEL,
        EV_CLR_WEL,
        EV_SR_HOLD,
        EV_SR_REFUSE,
        EV_SR_ABORT,
        EV_SR_START,
        EV_ARR_START,
        EV_ARR_REFUSE,
        EV_BUSY_REFUSE
    } event_e;

    typedef struct packed {
        logic       arm;
        logic [2:0] zero;
        logic [1:0] region;
        logic       wel;
        logic       busy;
    } status_t;

    // region selector against the two most significant address bits
    function automatic logic region_locked(input logic [1:0] region,
                                           input logic [1:0] top2);
        case (region)
            2'b00:   return 1'b0;
            2'b01:   return (top2 == 2'b11);
            2'b10:   return top2[1];
            default: return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/srwp_judge.sv
module srwp_judge
    import srwp_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              busy,
    input  logic              wel,
    input  logic [1:0]        region,
    input  logic              arm,
    input  logic              wp_n,
    input  logic              cs_n,
    input  logic              pending,
    input  logic              set_wel,
    input  logic              clr_wel,
    input  logic              sr_req,
    input  logic              arr_req,
    input  logic [ADDR_W-1:0] arr_addr,
    output event_e            ev
);
    localparam int MSB = ADDR_W - 1;

    logic pin_blocks;
    logic locked;

    assign pin_blocks = arm && !wp_n;
    assign locked     = region_locked(region, arr_addr[MSB -: 2]);

    always_comb begin
        ev = EV_NONE;
        if (busy) begin
            if (set_wel || clr_wel || sr_req || arr_req)
                ev = EV_BUSY_REFUSE;
        end else if (pending) begin
            if (cs_n)
                ev = EV_SR_START;
            else if (pin_blocks)
                ev = EV_SR_ABORT;
        end else if (set_wel) begin
            ev = EV_SET_WEL;
        end else if (clr_wel) begin
            ev = EV_CLR_WEL;
        end else if (sr_req) begin
            if (!wel || pin_blocks)
                ev = EV_SR_REFUSE;
            else
                ev = EV_SR_HOLD;
        end else if (arr_req) begin
            if (!wel || locked)
                ev = EV_ARR_REFUSE;
            else
                ev = EV_ARR_START;
        end
    end
endmodule

// File: rtl/srwp_timer.sv
module srwp_timer #(
    parameter int WRITE_CYCLES = 10000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic finishing
);
    localparam int CNT_W = $clog2(WRITE_CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(WRITE_CYCLES);

    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)
            remain <= '0;
        else if (start)
            remain <= LOAD;
        else if (remain != '0)
            remain <= remain - 1'b1;
    end

    assign busy      = (remain != '0);
    assign finishing = (remain == CNT_W'(1));

    a_r7_start_busy: assert property (@(posedge clk) disable iff (rst)
        start |=> busy);
    a_r7_bound: assert property (@(posedge clk) disable iff (rst)
        remain <= LOAD);
    a_r9_no_restart: assert property (@(posedge clk) disable iff (rst)
        busy |-> !start);
endmodule

// File: rtl/srwp_unit.sv
module srwp_unit
    import srwp_pkg::*;
#(
    parameter int ADDR_W       = 15,
    parameter int WRITE_CYCLES = 10000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              wp_n,
    input  logic              set_wel,
    input  logic              clr_wel,
    input  logic              sr_req,
    input  logic [7:0]        sr_data,
    input  logic              arr_req,
    input  logic [ADDR_W-1:0] arr_addr,
    output logic [7:0]        status,
    output logic              grant,
    output logic              deny,
    output logic              busy
);
    event_e    ev;
    logic      wel, arm, pending, pend_arm;
    logic [1:0] region, pend_region;
    logic      cyc_start, finishing;
    status_t   sr;

    srwp_judge #(.ADDR_W(ADDR_W)) u_judge (
        .busy(busy), .wel(wel), .region(region), .arm(arm), .wp_n(wp_n),
        .cs_n(cs_n), .pending(pending), .set_wel(set_wel), .clr_wel(clr_wel),
        .sr_req(sr_req), .arr_req(arr_req), .arr_addr(arr_addr), .ev(ev)
    );

    assign cyc_start = (ev == EV_SR_START) || (ev == EV_ARR_START);

    srwp_timer #(.WRITE_CYCLES(WRITE_CYCLES)) u_timer (
        .clk(clk), .rst(rst), .start(cyc_start),
        .busy(busy), .finishing(finishing)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wel         <= 1'b0;
            arm         <= 1'b0;
            region      <= 2'b00;
            pending     <= 1'b0;
            pend_arm    <= 1'b0;
            pend_region <= 2'b00;
            grant       <= 1'b0;
            deny        <= 1'b0;
        end else begin
            grant <= 1'b0;
            deny  <= 1'b0;
            if (finishing)
                wel <= 1'b0;
            case (ev)
                EV_SET_WEL: wel <= 1'b1;
                EV_CLR_WEL: wel <= 1'b0;
                EV_SR_HOLD: begin
                    pending     <= 1'b1;
                    pend_region <= sr_data[3:2];
                    pend_arm    <= sr_data[7];
                end
                EV_SR_REFUSE: begin
                    deny <= 1'b1;
                    wel  <= 1'b0;
                end
                EV_SR_ABORT: begin
                    pending <= 1'b0;
                    deny    <= 1'b1;
                    wel     <= 1'b0;
                end
                EV_SR_START: begin
                    pending <= 1'b0;
                    grant   <= 1'b1;
                    region  <= pend_region;
                    arm     <= pend_arm;
                end
                EV_ARR_START:  grant <= 1'b1;
                EV_ARR_REFUSE: begin
                    deny <= 1'b1;
                    wel  <= 1'b0;
                end
                EV_BUSY_REFUSE: deny <= 1'b1;
                default: ;
            endcase
        end
    end

    always_comb begin
        sr.arm    = arm;
        sr.zero   = 3'b000;
        sr.region = region;
        sr.wel    = wel;
        sr.busy   = busy;
    end
    assign status = sr;

    a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(grant && deny));
    a_r4_pin_blocks: assert property (@(posedge clk) disable iff (rst)
        (sr_req && !busy && !pending && !set_wel && !clr_wel && arm && !wp_n)
        |=> (deny && !grant && !wel));
    a_r8_all_locked: assert property (@(posedge clk) disable iff (rst)
        (arr_req && !busy && !pending && !set_wel && !clr_wel && !sr_req
         && region == 2'b11) |=> (deny && !busy));
    a_r7_rise_granted: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> grant);
    a_r7_wel_cleared: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> !wel);
    a_r6_frozen: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ($stable(region) && $stable(arm)));
    a_r3_no_wel_no_grant: assert property (@(posedge clk) disable iff (rst)
        (arr_req && !busy && !pending && !set_wel && !clr_wel && !sr_req && !wel)
        |=> !grant);
endmodule

// File: tb/srwp_unit_bench.sv
module srwp_unit_bench;
    localparam int CLK_P  = 10;
    localparam int AW     = 6;
    localparam int NCYC   = 5;
    localparam int NVEC   = 12;

    // {region[1:0], addr[5:0], expect_grant}
    localparam logic [8:0] VEC [NVEC] = '{
        {2'b00, 6'd63, 1'b1}, {2'b00, 6'd0,  1'b1},
        {2'b01, 6'd47, 1'b1}, {2'b01, 6'd48, 1'b0},
        {2'b01, 6'd63, 1'b0}, {2'b10, 6'd31, 1'b1},
        {2'b10, 6'd32, 1'b0}, {2'b11, 6'd0,  1'b0},
        {2'b11, 6'd63, 1'b0}, {2'b01, 6'd0,  1'b1},
        {2'b10, 6'd63, 1'b0}, {2'b00, 6'd32, 1'b1}
    };

    logic clk = 1'b0;
    logic rst, cs_n, wp_n, set_wel, clr_wel, sr_req, arr_req;
    logic [7:0] sr_data;
    logic [AW-1:0] arr_addr;
    logic [7:0] status;
    logic grant, deny, busy;
    int total = 0;
    int bad = 0;
    logic ended = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    srwp_unit #(.ADDR_W(AW), .WRITE_CYCLES(NCYC)) u_srwp_unit (
        .clk(clk), .rst(rst), .cs_n(cs_n), .wp_n(wp_n), .set_wel(set_wel),
        .clr_wel(clr_wel), .sr_req(sr_req), .sr_data(sr_data),
        .arr_req(arr_req), .arr_addr(arr_addr), .status(status),
        .grant(grant), .deny(deny), .busy(busy)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_wren();
        set_wel = 1'b1; tick(); set_wel = 1'b0;
    endtask

    task automatic do_wrdi();
        clr_wel = 1'b1; tick(); clr_wel = 1'b0;
    endtask

    task automatic sr_issue(input logic [7:0] d);
        cs_n = 1'b0; sr_data = d; sr_req = 1'b1; tick(); sr_req = 1'b0;
    endtask

    task automatic cs_rise();
        cs_n = 1'b1; tick();
    endtask

    task automatic arr_issue(input logic [AW-1:0] a);
        arr_addr = a; arr_req = 1'b1; tick(); arr_req = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 50 && busy; i++) tick();
    endtask

    task automatic set_sr(input logic [7:0] d);
        do_wren(); sr_issue(d); cs_rise(); wait_idle();
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog act=running exp=finished");
        finish_run();
    end

    initial begin
        int n;
        rst = 1'b1; cs_n = 1'b1; wp_n = 1'b1; set_wel = 1'b0; clr_wel = 1'b0;
        sr_req = 1'b0; arr_req = 1'b0; sr_data = '0; arr_addr = '0;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        check("R1 reset status", status, 8'h00);
        check("R1 reset grant/deny/busy", {grant, deny, busy}, 3'b000);

        do_wren();
        check("R2 latch set", status, 8'h02);
        do_wrdi();
        check("R2 latch cleared", status, 8'h00);

        sr_issue(8'h8C);
        check("R3 status write without latch denied", {grant, deny}, 2'b01);
        cs_rise();
        check("R3 status unchanged", status, 8'h00);
        arr_issue(6'd0);
        check("R3 array write without latch denied", {grant, deny, busy}, 3'b010);

        for (int i = 0; i < NVEC; i++) begin
            logic [1:0] rg;
            logic [5:0] ad;
            logic ex;
            {rg, ad, ex} = VEC[i];
            set_sr({4'b0000, rg, 2'b00});
            check("R5 region written", status, {4'b0000, rg, 2'b00});
            do_wren();
            arr_issue(ad);
            check("R8 region decision", {grant, deny}, {ex, ~ex});
            check("R8 busy follows decision", busy, ex);
            if (!ex) check("R8 refusal clears latch", status[1], 1'b0);
            wait_idle();
            check("R7 latch clear after idle", status[1], 1'b0);
        end

        set_sr(8'h00);
        do_wren();
        arr_issue(6'd5);
        check("R7 array grant", grant, 1'b1);
        n = 0;
        for (int i = 0; i < 50 && busy; i++) begin n++; tick(); end
        check("R7 busy length", n, NCYC);
        check("R7 latch cleared at end", status, 8'h00);

        do_wren();
        arr_issue(6'd1);
        set_wel = 1'b1; tick(); set_wel = 1'b0;
        check("R9 request while busy denied", {grant, deny}, 2'b01);
        sr_issue(8'h8C); cs_n = 1'b1;
        check("R9 status request while busy denied", deny, 1'b1);
        wait_idle();
        check("R9 no state change", status, 8'h00);

        wp_n = 1'b0;
        do_wren();
        sr_issue(8'h84);
        cs_rise();
        check("R4 pin ignored when unarmed", {grant, status}, {1'b1, 8'h87});
        wait_idle();
        check("R4 armed status", status, 8'h84);

        do_wren();
        sr_issue(8'h00);
        check("R4 armed pin refuses", {grant, deny}, 2'b01);
        check("R4 refusal clears latch", status, 8'h84);
        cs_rise();
        check("R4 no commit after refusal", {grant, status}, {1'b0, 8'h84});

        wp_n = 1'b1;
        do_wren();
        sr_issue(8'h08);
        check("R5 pending no pulse", {grant, deny}, 2'b00);
        wp_n = 1'b0; tick();
        check("R5 abort while pending", {grant, deny}, 2'b01);
        check("R5 abort keeps status", status, 8'h84);
        cs_rise();
        check("R5 nothing after abort", {grant, status}, {1'b0, 8'h84});

        wp_n = 1'b1;
        do_wren();
        sr_issue(8'h88);
        cs_n = 1'b1; wp_n = 1'b0; tick();
        check("R5 commit wins over pin", {grant, deny, status}, {2'b10, 8'h8B});
        n = 0;
        for (int i = 0; i < 50 && busy; i++) begin
            wp_n = ~wp_n; n++; tick();
        end
        check("R6 cycle length unaffected", n, NCYC);
        check("R6 status kept", status, 8'h88);

        wp_n = 1'b1;
        set_sr(8'h00);
        check("R5 disarm", status, 8'h00);

        finish_run();
    end
endmodule